// File: doc/BRIEF.md
# Dual Two-Input Event Counter

This block contains two separate up-counters that share a fast system clock. Each counter has three asynchronous control inputs: a count-clock input, a count-enable input and a clear input. It drives a `CNT_W`-bit count output. A parameter selects the counting range. It is either the full binary range (modulo 2^`CNT_W`, so 16 with the default width) or decade counting (modulo 10).

A counter advances in two cases:
- its count-clock input rises while its enable is high;
- its enable falls while its count-clock input is low.

Either input can therefore act as the count input, and the other acts as its qualifier. Counters are chained by routing the top count bit of one lane into the enable of the next lane, with the next lane's count-clock held low. The next lane then advances each time the previous lane wraps.

Each control input passes through a two-flop synchronizer. Edges are found by comparing the newest synchronized sample with the sample before it. All count state is updated on the system clock.

Top module: `dual_event_counter`

## Requirements
- R1: While `rst_n` is low at a rising system-clock edge, every count register and synchronizer stage is cleared, so all counts read 0 after reset.
- R2: A rising edge on a lane's count-clock input while its enable is high, with the enable unchanged, adds one to that lane's count.
- R3: A falling edge on a lane's enable while its count-clock input is low, with the count-clock unchanged, adds one to that lane's count.
- R4: A falling edge on the count-clock input, or a rising edge on the enable, leaves the count unchanged.
- R5: A rising count-clock edge while the enable is low, or a falling enable edge while the count-clock is high, leaves the count unchanged.
- R6: A high level on a lane's clear input forces that count to 0 and overrides any count event in the same sample.
- R7: With `DECIMAL`=0 the count runs 0..2^`CNT_W`-1 and wraps from the top value to 0.
- R8: With `DECIMAL`=1 the count runs 0..9 and wraps from 9 to 0. Any value above 9 goes to 0 on the next step.
- R9: The two lanes are independent: inputs of one lane never change the other lane's count.
- R10: If the count-clock and the enable of a lane both change in the same synchronized sample, no count occurs.
- R11: An input change applied between system-clock edges is visible at the count output right after the third rising system-clock edge that follows it, and not before.
- R12: With lane 1's enable fed from lane 0's count bit `CNT_W-1` and lane 1's count-clock held low, lane 1 advances once each time that bit falls. That happens on the wrap from 15 in binary mode and from 9 in decade mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_clk | input | LANES | Count-clock input per lane (asynchronous) |
| cnt_en | input | LANES | Enable input per lane (asynchronous) |
| cnt_clr | input | LANES | Clear input per lane, active high (asynchronous) |
| cnt_q | output | LANES*CNT_W | Counts; lane n occupies bits [n*CNT_W +: CNT_W] |

## Verification
The assertions assume that every control input stays at one level for at least one system-clock period. Under that assumption each real transition shows up as exactly one edge between consecutive synchronized samples. The stimulus always drives inputs on the falling system-clock edge. Each level is held for at least one full period, and most directed pulses are held for two. The cascade wiring follows the same rule because the count bit changes only once per period. Simultaneous changes of both inputs are created on purpose, both in directed steps and in random steps, to exercise the suppression rule.

// File: rtl/ctr_pkg.sv
// Package for the dual event counter.
// Holds the per-lane sample record and the modulus helper.
package ctr_pkg;

    // One synchronized sample of a lane's three control inputs.
    typedef struct packed {
        logic clr;
        logic en;
        logic ck;
    } lane_smp_t;

    // Number of states for the chosen counting range.
    function automatic int count_mod(input int width, input bit decimal);
        return decimal ? 10 : (1 << width);
    endfunction

endpackage

// File: rtl/edge_sync.sv
// edge_sync: two-flop synchronizer plus one history stage for edge detection.
// Assumes: raw inputs are asynchronous to clk, and each level is held for
// at least one clk period. Output cur is the newest safe sample and prv is
// the sample taken one clk earlier.
module edge_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prv
);
    logic [W-1:0] meta_q;
    logic [W-1:0] safe_q;
    logic [W-1:0] hist_q;

    // Shift the raw inputs through two sync stages and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            safe_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= raw;
            safe_q <= meta_q;
            hist_q <= safe_q;
        end
    end

    assign cur = safe_q;
    assign prv = hist_q;
endmodule

// File: rtl/step_decode.sv
// step_decode: turns two consecutive samples of a lane into a count request.
// Assumes: cur and prv come from edge_sync, one clk apart. clk and rst_n
// are used only by the assertions.
module step_decode
    import ctr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  lane_smp_t cur,
    input  lane_smp_t prv,
    output logic      step
);
    logic ck_rise;
    logic en_fall;
    logic both_moved;

    // Find the two qualifying edges and the simultaneous-change veto.
    always_comb begin
        ck_rise    = cur.ck & ~prv.ck & cur.en;
        en_fall    = ~cur.en & prv.en & ~cur.ck;
        both_moved = (cur.ck ^ prv.ck) & (cur.en ^ prv.en);
        step       = (ck_rise | en_fall) & ~both_moved;
    end

    // R4
    fall_clk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prv.ck && !cur.ck) |-> !step);
    // R4
    rise_en_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prv.en && cur.en) |-> !step);
    // R5
    rise_clk_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prv.ck && cur.ck && !cur.en) |-> !step);
    // R5
    fall_en_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prv.en && !cur.en && cur.ck) |-> !step);
    // R10
    both_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((prv.ck != cur.ck) && (prv.en != cur.en)) |-> !step);
endmodule

// File: rtl/lane_counter.sv
// lane_counter: modulo-MODV up-counter with synchronous clear priority.
// Assumes: clr and step are synchronized, single-cycle qualified signals.
// A value at or above MODV-1 goes to 0 on the next step.
module lane_counter #(
    parameter int CNT_W = 4,
    parameter int MODV  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [CNT_W-1:0] q
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MODV - 1);

    logic [CNT_W-1:0] cnt_q;

    // Clear has priority over a step; a step past LAST wraps to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= (cnt_q >= LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign q = cnt_q;

    // R6
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));
    // R7 R8
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && step && q == LAST) |=> (q == '0));
    // R4 R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step) |=> $stable(q));
endmodule

// File: rtl/dual_event_counter.sv
// dual_event_counter: LANES independent two-input event counters.
// Assumes: all control inputs are asynchronous and held for at least one
// clk period. DECIMAL selects modulo-10, otherwise modulo 2^CNT_W.
module dual_event_counter
    import ctr_pkg::*;
#(
    parameter int LANES   = 2,
    parameter int CNT_W   = 4,
    parameter bit DECIMAL = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES-1:0]       cnt_clk,
    input  logic [LANES-1:0]       cnt_en,
    input  logic [LANES-1:0]       cnt_clr,
    output logic [LANES*CNT_W-1:0] cnt_q
);
    localparam int MODV  = count_mod(CNT_W, DECIMAL);
    localparam int SMP_W = $bits(lane_smp_t);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_smp_t  raw_s;
        lane_smp_t  cur_s;
        lane_smp_t  prv_s;
        logic       step_s;

        // Gather this lane's pins into one sample record.
        always_comb begin
            raw_s.clr = cnt_clr[g];
            raw_s.en  = cnt_en[g];
            raw_s.ck  = cnt_clk[g];
        end

        edge_sync #(.W(SMP_W)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_s),
            .cur   (cur_s),
            .prv   (prv_s)
        );

        step_decode u_dec (
            .clk   (clk),
            .rst_n (rst_n),
            .cur   (cur_s),
            .prv   (prv_s),
            .step  (step_s)
        );

        lane_counter #(.CNT_W(CNT_W), .MODV(MODV)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cur_s.clr),
            .step  (step_s),
            .q     (cnt_q[g*CNT_W +: CNT_W])
        );
    end
endmodule

// File: tb/sim_dual_event_counter.sv
`timescale 1ns/1ps
module sim_dual_event_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ck = '0;
    logic       en0 = 1'b0;
    logic       en1_drv = 1'b0;
    logic [1:0] clr = '0;
    logic       casc = 1'b0;
    logic [7:0] q0, q1;
    logic [1:0] env0, env1;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // The two instances share stimulus except for the cascade feed.
    assign env0 = {casc ? q0[3] : en1_drv, en0};
    assign env1 = {casc ? q1[3] : en1_drv, en0};

    always #2 clk = ~clk;

    dual_event_counter #(.DECIMAL(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_clk(ck), .cnt_en(env0),
        .cnt_clr(clr), .cnt_q(q0));
    dual_event_counter #(.DECIMAL(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .cnt_clk(ck), .cnt_en(env1),
        .cnt_clr(clr), .cnt_q(q1));

    // Reference model: per-instance history of pin snapshots and counts.
    logic [5:0] hist [2][3];
    int         expq [2][2];

    function automatic logic [5:0] snap(input int i);
        logic [1:0] e;
        e = (i == 0) ? env0 : env1;
        return {clr[1], e[1], ck[1], clr[0], e[0], ck[0]};
    endfunction

    // A count taken at edge n uses the pins seen at edges n-2 and n-3.
    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (!rst_n) begin
                for (int k = 0; k < 3; k++) hist[i][k] = '0;
                expq[i][0] = 0;
                expq[i][1] = 0;
            end else begin
                for (int j = 0; j < 2; j++) begin
                    logic [2:0] c, p;
                    int m;
                    bit inc;
                    m = (i == 0) ? 16 : 10;
                    c = hist[i][1][j*3 +: 3];
                    p = hist[i][2][j*3 +: 3];
                    inc = (c[0] && !p[0] && c[1]) || (!c[1] && p[1] && !c[0]);
                    if ((c[0] != p[0]) && (c[1] != p[1])) inc = 0;
                    if (c[2]) expq[i][j] = 0;
                    else if (inc) expq[i][j] = (expq[i][j] >= m - 1) ? 0 : expq[i][j] + 1;
                end
                hist[i][2] = hist[i][1];
                hist[i][1] = hist[i][0];
                hist[i][0] = snap(i);
            end
        end
    end

    task automatic chk(input int act, input int exp, input string t);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", t, act, exp, $time);
        end
    endtask

    // Compare every lane of both instances with the model on each cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(q0[3:0], expq[0][0], {tag, " u0 lane0"});
            chk(q0[7:4], expq[0][1], {tag, " u0 lane1"});
            chk(q1[3:0], expq[1][0], {tag, " u1 lane0"});
            chk(q1[7:4], expq[1][1], {tag, " u1 lane1"});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse0(input int n);
        for (int k = 0; k < n; k++) begin
            ck[0] = 1'b1; tick(2);
            ck[0] = 1'b0; tick(2);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(1);
        tag = "R1";
        chk(q0, 0, "R1 reset u0");
        chk(q1, 0, "R1 reset u1");

        // R11: one qualifying rise, watch its arrival edge by edge.
        en0 = 1'b1; tick(1);
        ck[0] = 1'b1;
        tick(1); chk(q0[3:0], 0, "R11 after 1 edge");
        tick(1); chk(q0[3:0], 0, "R11 after 2 edges");
        tick(1); chk(q0[3:0], 1, "R11 after 3 edges");
        ck[0] = 1'b0; tick(2);

        tag = "R2"; pulse0(4); tick(4);
        chk(q0[3:0], 5, "R2 count-clock rises");
        chk(q0[7:4], 0, "R9 lane1 untouched");

        tag = "R3";
        for (int k = 0; k < 3; k++) begin
            en0 = 1'b0; tick(2); en0 = 1'b1; tick(2);
        end
        tick(4);
        chk(q0[3:0], 8, "R3 enable falls");

        tag = "R4 R5";
        ck[0] = 1'b1; tick(3);   // counts once (R2), en high
        en0 = 1'b0; tick(2);     // fall en with clk high: R5
        en0 = 1'b1; tick(2);     // rise en: R4
        ck[0] = 1'b0; tick(2);   // fall clk: R4
        en0 = 1'b0; tick(2);     // counts once (R3)
        ck[0] = 1'b1; tick(2);   // rise clk, en low: R5
        ck[0] = 1'b0; tick(4);
        chk(q0[3:0], 10, "R4 R5 ignored edges");

        tag = "R10";
        ck[0] = 1'b1; en0 = 1'b1; tick(3);
        ck[0] = 1'b0; en0 = 1'b0; tick(3);
        ck[0] = 1'b1; en0 = 1'b1; tick(3);
        ck[0] = 1'b0; tick(4);
        chk(q0[3:0], 10, "R10 joint change u0");
        chk(q1[3:0], 0,  "R10 joint change u1");

        tag = "R6";
        clr[0] = 1'b1; pulse0(3); clr[0] = 1'b0; tick(4);
        chk(q0[3:0], 0, "R6 clear overrides");

        tag = "R7 R8"; pulse0(16); tick(4);
        chk(q0[3:0], 0, "R7 binary wrap");
        chk(q1[3:0], 6, "R8 decade wrap");

        tag = "R9";
        en1_drv = 1'b1; tick(1);
        for (int k = 0; k < 3; k++) begin
            ck[1] = 1'b1; tick(2); ck[1] = 1'b0; tick(2);
        end
        tick(4);
        chk(q0[7:4], 3, "R9 lane1 own count");
        chk(q0[3:0], 0, "R9 lane0 unaffected");

        tag = "R12";
        clr = 2'b11; en1_drv = 1'b0; tick(4);
        clr = 2'b00; casc = 1'b1; tick(4);
        pulse0(20); tick(6);
        chk(q0[3:0], 4, "R12 u0 lane0");
        chk(q0[7:4], 1, "R12 u0 cascade");
        chk(q1[3:0], 0, "R12 u1 lane0");
        chk(q1[7:4], 2, "R12 u1 cascade");

        // Random mix of R2 R3 R4 R5 R6 R10 with cascade on and off.
        tag = "random R2 R3 R4 R5 R6 R10 R12";
        for (int k = 0; k < 3000; k++) begin
            if (k % 500 == 0) casc = ~casc;
            ck[0]   = 1'($urandom);
            en0     = 1'($urandom);
            ck[1]   = casc ? 1'b0 : 1'($urandom);
            en1_drv = 1'($urandom);
            clr[0]  = ($urandom % 40) == 0;
            clr[1]  = ($urandom % 40) == 0;
            tick(1 + ($urandom % 3));
        end
        tick(6);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule